// File: doc/BRIEF.md
# Double-Banked Convolution Weight Store

The block holds convolution weights in two equal banks of 16-bit words. At any time one bank is the active bank, and the compute array reads its weights from that bank through a synchronous read port. The other bank is the standby bank. An external stream fills the standby bank with the weights for the next convolution, using a valid/ready handshake. Both banks together hold 36 Kb, so each bank holds 1152 words.

Before each convolution the compute controller raises a start request. The block grants the request only when no convolution is running and the standby bank holds the full programmed number of words. On a grant the two banks trade roles. The bank that was just filled becomes active, and the bank that was active becomes the new standby bank, which is then refilled. A request that cannot be granted stalls until the fill is complete, which keeps compute from starting on a partly loaded weight set.

Top module: `wbuf_pingpong`

## Requirements
- R1: After reset, bank 1 is active (`active_bank_o` = 1), so bank 0 is the first bank loaded. `active_valid_o`, `standby_full_o` and `conv_busy_o` are all 0.
- R2: A word is accepted on a cycle with `wr_valid_i` and `wr_ready_o` both high. Accepted words go to the standby bank at addresses 0, 1, 2 and so on. The address restarts at 0 after each bank swap.
- R3: When the number of accepted words reaches `wcount_i` (capped at the bank depth), `standby_full_o` goes high on the next cycle and `wr_ready_o` goes low. Both stay that way until the next swap, and words offered in the meantime are discarded.
- R4: `conv_go_o` is high in the same cycle as `conv_req_i` only when no convolution is running and the standby bank is full. Otherwise the request stalls and the active bank does not change.
- R5: On the clock edge of a grant, `active_bank_o` toggles, `conv_busy_o` and `active_valid_o` go to 1, and `standby_full_o` goes to 0.
- R6: While `conv_busy_o` is 1, no swap happens, even when a request arrives and the standby bank is full. A `conv_done_i` pulse clears `conv_busy_o` on the next edge.
- R7: `rd_data_o` gives the word at `rd_addr_i` one cycle after the address is presented. The word comes from the bank that was active in the address cycle.
- R8: Writes never change the contents of the active bank.
- R9: With `wcount_i` = 0, `wr_ready_o` stays low and the standby bank never reports full.
- R10: A `conv_done_i` pulse while no convolution is running has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wcount_i | input | 11 | Number of words that make up a complete weight set |
| wr_valid_i | input | 1 | Fill stream word valid |
| wr_data_i | input | 16 | Fill stream weight word |
| wr_ready_o | output | 1 | Standby bank can accept a word |
| rd_addr_i | input | 11 | Read address into the active bank |
| rd_data_o | output | 16 | Weight word, one cycle after the address |
| conv_req_i | input | 1 | Request to start the next convolution |
| conv_go_o | output | 1 | Start granted; banks swap on this edge |
| conv_done_i | input | 1 | Current convolution finished |
| conv_busy_o | output | 1 | A convolution is running |
| active_bank_o | output | 1 | Index of the bank feeding compute |
| active_valid_o | output | 1 | Active bank holds a complete weight set |
| standby_full_o | output | 1 | Standby bank holds a complete weight set |

## Verification
The checker verifies the bank-role rules on every cycle. A grant toggles the active bank and clears the full flag, no role change happens without a grant or while busy, a full standby bank refuses writes, and the full flag holds until the swap. Some behaviour can only be shown by the bench scenarios, which fill a bank and then read it back. These cover where each accepted word lands, what the read port returns one cycle after each address, that the active bank is not disturbed while the standby bank is loading, and that excess or zero-count fills are discarded.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int unsigned WBUF_TOTAL_BITS = 36864;
  localparam int unsigned WBUF_DW         = 16;
  localparam int unsigned WBUF_NBANK      = 2;
  localparam int unsigned WBUF_DEPTH      = WBUF_TOTAL_BITS / (WBUF_NBANK * WBUF_DW);

  typedef logic bank_sel_t;
endpackage

// File: rtl/wbuf_bank.sv
module wbuf_bank #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 1152,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/wbuf_fill_ctrl.sv
module wbuf_fill_ctrl #(
  parameter int unsigned DEPTH = 1152,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [CW-1:0] wcount_i,
  input  logic          clear_i,
  output logic          wr_ready_o,
  output logic          fire_o,
  output logic [AW-1:0] waddr_o,
  output logic          full_o
);
  localparam logic [CW-1:0] DepthC = CW'(DEPTH);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          full_q;

  // clamp programmed count to the bank depth
  assign limit      = (wcount_i > DepthC) ? DepthC : wcount_i;
  assign wr_ready_o = !full_q && (cnt_q < limit);
  assign fire_o     = wr_valid_i && wr_ready_o;
  assign waddr_o    = AW'(cnt_q);
  assign full_o     = full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (fire_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q + 1'b1 == limit) full_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wbuf_swap_ctrl.sv
module wbuf_swap_ctrl
  import wbuf_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      conv_req_i,
  input  logic      conv_done_i,
  input  logic      standby_full_i,
  output logic      conv_go_o,
  output logic      busy_o,
  output bank_sel_t active_o,
  output logic      valid_o
);
  bank_sel_t active_q;
  logic      busy_q;
  logic      valid_q;

  // swap only at a convolution boundary with a complete standby set
  assign conv_go_o = conv_req_i && !busy_q && standby_full_i;
  assign busy_o    = busy_q;
  assign active_o  = active_q;
  assign valid_o   = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      busy_q   <= 1'b0;
      valid_q  <= 1'b0;
    end else if (conv_go_o) begin
      active_q <= ~active_q;
      busy_q   <= 1'b1;
      valid_q  <= 1'b1;
    end else if (conv_done_i && busy_q) begin
      busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wbuf_pingpong.sv
module wbuf_pingpong
  import wbuf_pkg::*;
#(
  parameter int unsigned DW    = WBUF_DW,
  parameter int unsigned DEPTH = WBUF_DEPTH,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] wcount_i,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_ready_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          conv_req_i,
  output logic          conv_go_o,
  input  logic          conv_done_i,
  output logic          conv_busy_o,
  output logic          active_bank_o,
  output logic          active_valid_o,
  output logic          standby_full_o
);
  bank_sel_t     active;
  bank_sel_t     rd_sel_q;
  logic          fire;
  logic          full;
  logic [AW-1:0] waddr;
  logic [DW-1:0] rdata [WBUF_NBANK];

  wbuf_fill_ctrl #(.DEPTH(DEPTH)) i_fill (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wcount_i   (wcount_i),
    .clear_i    (conv_go_o),
    .wr_ready_o (wr_ready_o),
    .fire_o     (fire),
    .waddr_o    (waddr),
    .full_o     (full)
  );

  wbuf_swap_ctrl i_swap (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .conv_req_i     (conv_req_i),
    .conv_done_i    (conv_done_i),
    .standby_full_i (full),
    .conv_go_o      (conv_go_o),
    .busy_o         (conv_busy_o),
    .active_o       (active),
    .valid_o        (active_valid_o)
  );

  for (genvar b = 0; b < WBUF_NBANK; b++) begin : g_bank
    logic we;
    // writes only ever land in the standby bank
    assign we = fire && (active != bank_sel_t'(b));
    wbuf_bank #(.DW(DW), .DEPTH(DEPTH)) i_bank (
      .clk_i   (clk_i),
      .we_i    (we),
      .waddr_i (waddr),
      .wdata_i (wr_data_i),
      .raddr_i (rd_addr_i),
      .rdata_o (rdata[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_sel_q <= 1'b1;
    else         rd_sel_q <= active;
  end

  assign rd_data_o      = rdata[rd_sel_q];
  assign active_bank_o  = active;
  assign standby_full_o = full;
endmodule

// File: rtl/wbuf_pingpong_chk.sv
module wbuf_pingpong_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_ready_o,
  input logic conv_req_i,
  input logic conv_go_o,
  input logic conv_busy_o,
  input logic active_bank_o,
  input logic active_valid_o,
  input logic standby_full_o
);
  AST_GRANT_FLIPS_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_go_o |=> active_bank_o != $past(active_bank_o)); // R5
  AST_GRANT_EMPTIES_STANDBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_go_o |=> !standby_full_o && conv_busy_o && active_valid_o); // R5
  AST_NO_FLIP_WITHOUT_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_go_o |=> $stable(active_bank_o)); // R4
  AST_NO_GRANT_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_busy_o |-> !conv_go_o); // R6
  AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_full_o |-> !wr_ready_o); // R3
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_full_o && !conv_go_o |=> standby_full_o); // R3
  AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_valid_o |=> active_valid_o); // R5
  AST_STALL_NOT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_i && !standby_full_o |-> !conv_go_o); // R4
endmodule

bind wbuf_pingpong wbuf_pingpong_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_ready_o     (wr_ready_o),
  .conv_req_i     (conv_req_i),
  .conv_go_o      (conv_go_o),
  .conv_busy_o    (conv_busy_o),
  .active_bank_o  (active_bank_o),
  .active_valid_o (active_valid_o),
  .standby_full_o (standby_full_o)
);

// File: tb/test_wbuf_pingpong.sv
module test_wbuf_pingpong;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DW = 16;
  localparam int unsigned DEPTH = 1152;
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [CW-1:0] wcount_i = '0;
  logic          wr_valid_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic          wr_ready_o;
  logic [AW-1:0] rd_addr_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          conv_req_i = 1'b0;
  logic          conv_go_o;
  logic          conv_done_i = 1'b0;
  logic          conv_busy_o;
  logic          active_bank_o;
  logic          active_valid_o;
  logic          standby_full_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  wbuf_pingpong i_wbuf_pingpong (
    .clk_i, .rst_ni, .wcount_i, .wr_valid_i, .wr_data_i, .wr_ready_o,
    .rd_addr_i, .rd_data_o, .conv_req_i, .conv_go_o, .conv_done_i,
    .conv_busy_o, .active_bank_o, .active_valid_o, .standby_full_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 active_bank", active_bank_o, 1);
    chk("R1 active_valid", active_valid_o, 0);
    chk("R1 standby_full", standby_full_o, 0);
    chk("R1 busy", conv_busy_o, 0);
  endtask

  task automatic t_zero_count();
    wcount_i = '0;
    wr_valid_i = 1'b1;
    wr_data_i = 16'hDEAD;
    #1 chk("R9 ready with zero count", wr_ready_o, 0);
    repeat (3) @(negedge clk_i);
    wr_valid_i = 1'b0;
    chk("R9 never full", standby_full_o, 0);
  endtask

  // fill n words base+i, then offer one extra word
  task automatic t_fill(int n, logic [15:0] base);
    wcount_i = CW'(n);
    for (int i = 0; i < n; i++) begin
      wr_valid_i = 1'b1;
      wr_data_i = base + 16'(i);
      #1 chk("R2 ready during fill", wr_ready_o, 1);
      @(negedge clk_i);
    end
    wr_data_i = 16'hBEEF;
    #1 chk("R3 ready after count", wr_ready_o, 0);
    chk("R3 standby_full", standby_full_o, 1);
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    chk("R3 full holds", standby_full_o, 1);
  endtask

  task automatic t_read(int n, logic [15:0] base, string req);
    for (int i = 0; i < n; i++) begin
      rd_addr_i = AW'(i);
      @(negedge clk_i);
      chk(req, rd_data_o, base + 16'(i));
    end
  endtask

  task automatic t_grant(logic exp_bank);
    conv_req_i = 1'b1;
    #1 chk("R4 go when idle and full", conv_go_o, 1);
    @(negedge clk_i);
    conv_req_i = 1'b0;
    chk("R5 bank toggled", active_bank_o, exp_bank);
    chk("R5 busy", conv_busy_o, 1);
    chk("R5 valid", active_valid_o, 1);
    chk("R5 standby cleared", standby_full_o, 0);
  endtask

  task automatic t_done();
    conv_done_i = 1'b1;
    @(negedge clk_i);
    conv_done_i = 1'b0;
    chk("R6 done clears busy", conv_busy_o, 0);
  endtask

  task automatic t_idle_done();
    conv_done_i = 1'b1;
    @(negedge clk_i);
    conv_done_i = 1'b0;
    chk("R10 busy unchanged", conv_busy_o, 0);
    chk("R10 bank unchanged", active_bank_o, 1);
    chk("R10 valid unchanged", active_valid_o, 0);
    chk("R10 full unchanged", standby_full_o, 1);
  endtask

  task automatic t_busy_hold();
    conv_req_i = 1'b1;
    #1 chk("R6 no go while busy", conv_go_o, 0);
    repeat (2) @(negedge clk_i);
    conv_req_i = 1'b0;
    chk("R6 bank held while busy", active_bank_o, 0);
  endtask

  task automatic t_stall(logic exp_bank);
    conv_req_i = 1'b1;
    #1 chk("R4 stall when not full", conv_go_o, 0);
    repeat (3) @(negedge clk_i);
    conv_req_i = 1'b0;
    chk("R4 bank held in stall", active_bank_o, exp_bank);
  endtask

  initial begin
    t_reset();
    t_zero_count();
    t_fill(8, 16'hA000);            // bank 0
    t_idle_done();
    t_grant(1'b0);
    t_read(8, 16'hA000, "R7 read bank0");
    t_fill(8, 16'h5B00);            // bank 1 while busy
    t_read(8, 16'hA000, "R8 active intact");
    t_busy_hold();
    t_done();
    t_grant(1'b1);
    t_read(8, 16'h5B00, "R7 read bank1");
    t_done();
    t_stall(1'b1);
    t_fill(5, 16'hC300);            // bank 0 again, address restarts
    t_done();
    t_grant(1'b0);
    t_read(5, 16'hC300, "R2 refill from address 0");
    rd_addr_i = AW'(5);
    @(negedge clk_i);
    chk("R3 extra word discarded", rd_data_o, 16'hA005);
    finished = 1'b1;
  end

  initial begin
    fork
      begin
        wait (finished);
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule